// File: doc/BRIEF.md
# Scatter-Gather Descriptor Segmenter

This block turns a stream of buffer segments, each given as a start address and a byte length, into the descriptor table that a bus-master disk DMA engine fetches. Each descriptor occupies two consecutive 32-bit words. The first word is the buffer address. The second word is the byte count and its flags. The block writes the words one at a time through a simple indexed write port into a table memory owned by the surrounding logic.

No descriptor may span a 64 KB address window. A segment that reaches past such a window is cut at the window edge. A normal-mode chunk of exactly 64 KB would encode as a zero count, so the block emits it as two 32 KB halves. After the last segment of a table has been turned into descriptors, the block sets the end marker on the final descriptor. It then pulses a done strobe that gives the number of descriptors built.

A second count format serves engines that count in 32-bit units and that have no end marker. The table has a fixed maximum number of descriptors. If a table does not fit, or if it has no descriptors at all, the block reports failure with a count of zero. The caller then falls back to programmed I/O for that request.

Top module: `sgd_splitter`

## Requirements
- R1: Each descriptor covers min(remaining segment bytes, 0x10000 − address[15:0]) bytes. Descriptors follow input order, and their addresses advance by the bytes already covered. Descriptor k puts its address word at index 2k and its count word at index 2k+1.
- R2: In normal mode the count word carries the chunk byte count in bits 15:0 and zeros in bits 30:16. Every word places its least significant byte on data bits 7:0.
- R3: In normal mode a 64 KB chunk at address A becomes two descriptors, each with count 0x8000. The first is at A and the second at A+0x8000. A normal-mode count word never has bits 15:0 equal to zero.
- R4: In normal mode, once the table's last segment is consumed, the count word of the final descriptor is written a second time with bit 31 set. This happens even when that last segment is empty. No other count word has bit 31 set.
- R5: With alt_count_i high, the count word is {((n >> 2) − 1) mod 2^16, 16'h0000}, where n is the 16-bit chunk count (0 for 64 KB). A 64 KB chunk stays one descriptor, and no end marker is written.
- R6: If the next descriptor, or the pair for a split 64 KB chunk, would exceed MAX_ENTRIES, nothing further is written. The rest of the table's segments, up to the one flagged last, are accepted and discarded. Done then reports ok_o=0 and entries_o=0.
- R7: Zero-length segments add no descriptors. A table that yields no descriptors reports ok_o=0 and entries_o=0 and writes nothing.
- R8: done_o is a one-cycle pulse. On success it comes with ok_o=1 and entries_o equal to the descriptor count. The next table starts again at index 0.
- R9: seg_ready_o is high only while the block waits for a segment or discards one, and no word is written while it is high.
- R10: After reset seg_ready_o is high, and wr_en_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_count_i | input | 1 | Select 32-bit-unit count format without end marker |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment accepted when valid and ready |
| seg_addr_i | input | 32 | Segment start address |
| seg_len_i | input | 32 | Segment length in bytes |
| seg_last_i | input | 1 | Segment closes the table |
| wr_en_o | output | 1 | Table word write strobe |
| wr_idx_o | output | $clog2(2*MAX_ENTRIES) | Table word index |
| wr_data_o | output | 32 | Table word value |
| done_o | output | 1 | Table finished, one-cycle pulse |
| ok_o | output | 1 | Table built successfully (valid with done_o) |
| entries_o | output | $clog2(MAX_ENTRIES+1) | Descriptor count, zero on failure (valid with done_o) |

## Verification
The assertions check several rules on every cycle. No chunk crosses a 64 KB window or exceeds the bytes still pending. A normal-mode count word never encodes zero. Writes stay inside the table and never coincide with seg_ready_o, and done_o is a single pulse. They also check that the end-marker rewrite is followed directly by completion. Only the bench scenarios can show the exact descriptor contents for boundary-crossing, 64 KB, alternate-format and zero-length cases. They also show that a pair that does not fit is refused as a whole, that discarded segments leave the table untouched, and that failure and success report the right counts.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int WORD_W = 32;
  localparam logic [31:0] END_MARK = 32'h8000_0000;
  localparam logic [16:0] WINDOW = 17'h1_0000;
  localparam logic [16:0] HALF_WINDOW = 17'h0_8000;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CNT,
    S_MARK,
    S_DRAIN,
    S_DONE
  } sgd_state_e;
endpackage

// File: rtl/sgd_chunk_calc.sv
module sgd_chunk_calc
  import sgd_pkg::*;
(
  input  logic [15:0] addr_lo_i,
  input  logic [31:0] rem_i,
  input  logic        split_en_i,
  output logic [16:0] chunk_o,
  output logic        pair_o
);
  logic [16:0] room;
  logic [16:0] raw;
  logic        full;

  always_comb begin
    room = WINDOW - {1'b0, addr_lo_i};
    raw  = (rem_i < {15'd0, room}) ? rem_i[16:0] : room;
    full = (raw == WINDOW);
    // a full window in normal mode is emitted as two halves
    pair_o  = full && split_en_i;
    chunk_o = pair_o ? HALF_WINDOW : raw;
  end
endmodule

// File: rtl/sgd_count_enc.sv
module sgd_count_enc
  import sgd_pkg::*;
(
  input  logic [15:0]       cnt16_i,
  input  logic              alt_i,
  output logic [WORD_W-1:0] word_o
);
  logic [15:0] units_m1;

  always_comb begin
    units_m1 = (cnt16_i >> 2) - 16'd1;
    word_o   = alt_i ? {units_m1, 16'h0000} : {16'h0000, cnt16_i};
  end
endmodule

// File: rtl/sgd_splitter.sv
module sgd_splitter
  import sgd_pkg::*;
#(
  parameter int MAX_ENTRIES = 256,
  localparam int IW = $clog2(2 * MAX_ENTRIES),
  localparam int CW = $clog2(MAX_ENTRIES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_count_i,
  input  logic              seg_valid_i,
  output logic              seg_ready_o,
  input  logic [31:0]       seg_addr_i,
  input  logic [31:0]       seg_len_i,
  input  logic              seg_last_i,
  output logic              wr_en_o,
  output logic [IW-1:0]     wr_idx_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              ok_o,
  output logic [CW-1:0]     entries_o
);
  localparam int CW1 = CW + 1;

  sgd_state_e        state_q;
  logic [31:0]       addr_q;
  logic [31:0]       rem_q;
  logic              last_q;
  logic              fail_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     mark_idx_q;
  logic [WORD_W-1:0] mark_word_q;

  logic [16:0]       chunk;
  logic              pair;
  logic [WORD_W-1:0] cnt_word;
  logic [IW-1:0]     base_idx;
  logic              no_room;
  logic              accept;

  sgd_chunk_calc u_chunk (
    .addr_lo_i (addr_q[15:0]),
    .rem_i     (rem_q),
    .split_en_i(!alt_count_i),
    .chunk_o   (chunk),
    .pair_o    (pair)
  );

  sgd_count_enc u_enc (
    .cnt16_i(chunk[15:0]),
    .alt_i  (alt_count_i),
    .word_o (cnt_word)
  );

  always_comb begin
    base_idx = IW'(cnt_q) << 1;
    no_room  = ({1'b0, cnt_q} + (pair ? CW1'(2) : CW1'(1))) > CW1'(MAX_ENTRIES);
    seg_ready_o = (state_q == S_IDLE) || (state_q == S_DRAIN);
    accept      = seg_ready_o && seg_valid_i;
    wr_en_o   = 1'b0;
    wr_idx_o  = base_idx;
    wr_data_o = addr_q;
    unique case (state_q)
      S_ADDR: wr_en_o = !no_room;
      S_CNT: begin
        wr_en_o   = 1'b1;
        wr_idx_o  = base_idx | IW'(1);
        wr_data_o = cnt_word;
      end
      S_MARK: begin
        wr_en_o   = 1'b1;
        wr_idx_o  = mark_idx_q;
        wr_data_o = mark_word_q | END_MARK;
      end
      default: ;
    endcase
    done_o    = (state_q == S_DONE);
    ok_o      = done_o && !fail_q;
    entries_o = ok_o ? cnt_q : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      rem_q       <= '0;
      last_q      <= 1'b0;
      fail_q      <= 1'b0;
      cnt_q       <= '0;
      mark_idx_q  <= '0;
      mark_word_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (accept) begin
          addr_q <= seg_addr_i;
          rem_q  <= seg_len_i;
          last_q <= seg_last_i;
          if (seg_len_i != '0) begin
            state_q <= S_ADDR;
          end else if (seg_last_i) begin
            if (cnt_q == '0) begin
              fail_q  <= 1'b1;
              state_q <= S_DONE;
            end else begin
              state_q <= alt_count_i ? S_DONE : S_MARK;
            end
          end
        end
        S_ADDR: begin
          if (no_room) begin
            fail_q  <= 1'b1;
            state_q <= last_q ? S_DONE : S_DRAIN;
          end else begin
            state_q <= S_CNT;
          end
        end
        S_CNT: begin
          cnt_q       <= cnt_q + CW'(1);
          mark_idx_q  <= base_idx | IW'(1);
          mark_word_q <= cnt_word;
          addr_q      <= addr_q + 32'(chunk);
          rem_q       <= rem_q - 32'(chunk);
          if (rem_q == 32'(chunk)) begin
            if (last_q) state_q <= alt_count_i ? S_DONE : S_MARK;
            else        state_q <= S_IDLE;
          end else begin
            state_q <= S_ADDR;
          end
        end
        S_MARK:  state_q <= S_DONE;
        S_DRAIN: if (accept && seg_last_i) state_q <= S_DONE;
        S_DONE: begin
          cnt_q   <= '0;
          fail_q  <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: an emitted chunk stays inside its 64 KB window and within the pending bytes
  a_r1_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CNT) |-> (chunk != '0 && 32'(chunk) <= rem_q &&
                            ({1'b0, addr_q[15:0]} + chunk) <= WINDOW));

  // R3: a normal-mode count word never encodes zero bytes
  a_r3_no_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o[0] && !alt_count_i) |-> (wr_data_o[15:0] != 16'h0000));

  // R4: the marked rewrite is the last act before completion
  a_r4_mark_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o[0] && wr_data_o[31] && !alt_count_i) |=> done_o);

  // R6: writes stay inside the table
  a_r6_idx_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (32'(wr_idx_o) < 32'(2 * MAX_ENTRIES)));

  // R6: a failed table reports zero descriptors
  a_r6_fail_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> (entries_o == '0));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: no table write while a segment may be taken
  a_r9_ready_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_ready_o |-> !wr_en_o);
endmodule

// File: tb/sgd_splitter_test.sv
module sgd_splitter_test;
  localparam int MAXE = 8;
  localparam int IW = $clog2(2 * MAXE);
  localparam int CW = $clog2(MAXE + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alt = 1'b0;
  logic          sv = 1'b0;
  logic          sr;
  logic [31:0]   sa = '0;
  logic [31:0]   sl = '0;
  logic          slast = 1'b0;
  logic          we;
  logic [IW-1:0] widx;
  logic [31:0]   wdat;
  logic          done;
  logic          ok;
  logic [CW-1:0] ents;

  int total = 0;
  int bad = 0;
  int nwr = 0;
  int clash = 0;
  bit done_seen = 0;
  bit got_ok = 0;
  int got_ents = 0;
  bit finished = 0;
  logic [31:0] mem [0:2*MAXE-1];

  always #10 clk = ~clk;

  sgd_splitter #(.MAX_ENTRIES(MAXE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .alt_count_i(alt),
    .seg_valid_i(sv), .seg_ready_o(sr), .seg_addr_i(sa), .seg_len_i(sl),
    .seg_last_i(slast), .wr_en_o(we), .wr_idx_o(widx), .wr_data_o(wdat),
    .done_o(done), .ok_o(ok), .entries_o(ents)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        mem[widx] = wdat;
        nwr++;
      end
      if (we && sr) clash++;
      if (done) begin
        done_seen = 1;
        got_ok = ok;
        got_ents = int'(ents);
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 2 * MAXE; i++) mem[i] = 32'hDEAD_BEEF;
    nwr = 0;
    done_seen = 0;
  endtask

  task automatic send(logic [31:0] a, logic [31:0] l, logic last);
    @(negedge clk);
    while (!sr) @(negedge clk);
    sv = 1'b1; sa = a; sl = l; slast = last;
    @(negedge clk);
    sv = 1'b0; slast = 1'b0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done_seen && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done seen", 32'(done_seen), 32'd1);
  endtask

  task automatic t_reset();
    chk("R10", "ready after reset", 32'(sr), 32'd1);
    chk("R10", "no write after reset", 32'(we), 32'd0);
    chk("R10", "no done after reset", 32'(done), 32'd0);
  endtask

  task automatic t_cross();
    clear_img();
    send(32'h0001_F0A4, 32'h3000, 1'b1);
    wait_done("R1");
    chk("R1", "entry0 addr", mem[0], 32'h0001_F0A4);
    chk("R1", "entry0 count", mem[1], 32'h0000_0F5C);
    chk("R1", "entry1 addr", mem[2], 32'h0002_0000);
    chk("R4", "entry1 count marked", mem[3], 32'h8000_20A4);
    chk("R2", "low byte lane", 32'(mem[0][7:0]), 32'hA4);
    chk("R8", "ok", 32'(got_ok), 32'd1);
    chk("R8", "entries", 32'(got_ents), 32'd2);
    chk("R4", "write count with mark", 32'(nwr), 32'd5);
  endtask

  task automatic t_full64();
    clear_img();
    send(32'h0003_0000, 32'h1_0000, 1'b1);
    chk("R9", "busy while emitting", 32'(sr), 32'd0);
    wait_done("R3");
    chk("R3", "half0 addr", mem[0], 32'h0003_0000);
    chk("R3", "half0 count", mem[1], 32'h0000_8000);
    chk("R3", "half1 addr", mem[2], 32'h0003_8000);
    chk("R3", "half1 count", mem[3], 32'h8000_8000);
    chk("R3", "entries", 32'(got_ents), 32'd2);
  endtask

  task automatic t_multi();
    clear_img();
    send(32'h0000_0100, 32'h200, 1'b0);
    send(32'h0000_5000, 32'h0, 1'b0);
    send(32'h0002_0000, 32'h10, 1'b1);
    wait_done("R7");
    chk("R7", "zero seg skipped addr", mem[2], 32'h0002_0000);
    chk("R4", "first not marked", mem[1], 32'h0000_0200);
    chk("R4", "last marked", mem[3], 32'h8000_0010);
    chk("R7", "entries", 32'(got_ents), 32'd2);
    clear_img();
    send(32'h0000_0100, 32'h200, 1'b0);
    send(32'h0000_0000, 32'h0, 1'b1);
    wait_done("R4");
    chk("R4", "mark after empty last", mem[1], 32'h8000_0200);
    chk("R4", "writes", 32'(nwr), 32'd3);
  endtask

  task automatic t_alt();
    alt = 1'b1;
    clear_img();
    send(32'h0004_0000, 32'h1_0400, 1'b1);
    wait_done("R5");
    chk("R5", "64K alt word", mem[1], 32'hFFFF_0000);
    chk("R5", "second addr", mem[2], 32'h0005_0000);
    chk("R5", "second alt word", mem[3], 32'h00FF_0000);
    chk("R5", "no mark rewrite", 32'(nwr), 32'd4);
    chk("R5", "entries", 32'(got_ents), 32'd2);
    alt = 1'b0;
  endtask

  task automatic t_empty();
    clear_img();
    send(32'h0000_1000, 32'h0, 1'b1);
    wait_done("R7");
    chk("R7", "ok low", 32'(got_ok), 32'd0);
    chk("R7", "entries zero", 32'(got_ents), 32'd0);
    chk("R7", "no writes", 32'(nwr), 32'd0);
  endtask

  task automatic t_exact_full();
    clear_img();
    send(32'h0000_0000, 32'h4_0000, 1'b1);
    wait_done("R6");
    chk("R6", "full table ok", 32'(got_ok), 32'd1);
    chk("R6", "full entries", 32'(got_ents), 32'(MAXE));
    chk("R6", "last addr", mem[14], 32'h0003_8000);
    chk("R6", "last count", mem[15], 32'h8000_8000);
    chk("R4", "prior unmarked", mem[13], 32'h0000_8000);
  endtask

  task automatic t_pair_no_room();
    clear_img();
    send(32'h0000_F000, 32'h3_1000, 1'b0);
    send(32'h0010_0000, 32'h1_0000, 1'b1);
    wait_done("R6");
    chk("R6", "pair refused ok", 32'(got_ok), 32'd0);
    chk("R6", "pair refused entries", 32'(got_ents), 32'd0);
    chk("R6", "pair refused writes", 32'(nwr), 32'd14);
    chk("R6", "slot untouched", mem[14], 32'hDEAD_BEEF);
  endtask

  task automatic t_drain();
    clear_img();
    send(32'h0000_0000, 32'h5_0000, 1'b0);
    send(32'h0090_0000, 32'h100, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6", "no done while draining", 32'(done_seen), 32'd0);
    send(32'h0000_0000, 32'h0, 1'b1);
    wait_done("R6");
    chk("R6", "drain ok low", 32'(got_ok), 32'd0);
    chk("R6", "drain entries", 32'(got_ents), 32'd0);
    chk("R6", "drained writes", 32'(nwr), 32'd16);
  endtask

  task automatic t_restart();
    clear_img();
    send(32'h0001_F0A4, 32'h3000, 1'b1);
    wait_done("R8");
    chk("R8", "restart at index 0", mem[0], 32'h0001_F0A4);
    chk("R8", "restart entries", 32'(got_ents), 32'd2);
  endtask

  initial begin
    for (int i = 0; i < 2 * MAXE; i++) mem[i] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cross();
    t_full64();
    t_multi();
    t_alt();
    t_empty();
    t_exact_full();
    t_pair_no_room();
    t_drain();
    t_restart();
    chk("R9", "write while ready", 32'(clash), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule